// File: doc/BRIEF.md
# Line Event Interrupt Register Bank

This block gathers fault indications from four external line-interface devices and turns them into sticky status bits that a host reads over a small synchronous register bus. Each device reports three conditions: loss of signal, loss of lock and driver-monitor failure. The block brings each raw level into the clock domain through a two-stage synchronizer. It then latches the level into a per-device event register, and the bit stays set after the condition goes away.

Software clears an event through a separate per-device reset register. That bit works as a hold, not a pulse. While it reads 1, the matching event bit is forced to 0 and new events on that line are not recorded. Writing it back to 0 turns recording back on. A per-device mask register chooses which events reach the single active-high interrupt line. Every access gets an acknowledge one clock after its strobe. Read data is returned together with that acknowledge.

Top module: `line_evt_bank`

## Requirements
- R1: Device d (0..3) owns three registers at byte addresses 0x30 + 0x10·d + k. The event register is at k = 0x0, the reset register at k = 0x4 and the mask register at k = 0x8. A read of offset 0xC in any device slot returns 0.
- R2: Each raw event input goes through a two-flop synchronizer. A level that is applied before clock edge n is first visible in the event register (and on the interrupt) after edge n+2, and not earlier.
- R3: In every register, bit 0 is loss of signal, bit 1 is loss of lock and bit 2 is driver-monitor failure. An event bit sets when its synchronized level is high and its reset bit is 0. It stays 1 after the input returns low.
- R4: Writing 1 to a reset-register bit clears the matching event bit. The event bit reads 0 for as long as the reset bit stays 1, even when the input stays high.
- R5: Writing 0 to a reset-register bit turns recording back on. If the condition is still active, the event bit reads 1 on the next access.
- R6: A mask bit of 1 enables that event. irq_o is the OR, over all devices and bits, of event AND mask. With every mask bit at 0, irq_o stays 0.
- R7: Every write strobe and every read strobe gives ack_o high for exactly the following cycle. rdata_o is valid in that cycle.
- R8: After reset, every register reads 0. The reset and mask registers read back the last value written to bits 2:0. Bits 31:3 of every register read 0.
- R9: Writes to an event register have no effect on its contents.
- R10: Events, clears and masks on one device do not change the registers of any other device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address of the access |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe, one cycle |
| rd_i | input | 1 | Read strobe, one cycle |
| rdata_o | output | 32 | Read data, valid with ack_o |
| ack_o | output | 1 | Access acknowledge, one cycle after the strobe |
| irq_o | output | 1 | Combined masked event interrupt, active high |
| los_i | input | 4 | Loss-of-signal level per device, asynchronous |
| lol_i | input | 4 | Loss-of-lock level per device, asynchronous |
| dmf_i | input | 4 | Driver-monitor failure level per device, asynchronous |

## Verification
The assertions check the following on every cycle:
- the two-edge synchronizer delay;
- that a set event bit stays set unless a clear is pending;
- that a held reset bit keeps its event at 0, and that a released bit with an active input sets the event;
- the acknowledge timing;
- that irq_o never rises while every mask bit is 0.

Other behaviours show only in the bench's directed scenarios. These are the address map and read-back values, the fact that event-register writes are ignored, the separation between devices, and the exact cycle in which the interrupt first rises after an input changes.

// File: rtl/line_evt_pkg.sv
`timescale 1ns/1ps
package line_evt_pkg;
  localparam int unsigned N_DEV     = 4;
  localparam int unsigned N_EVT     = 3;
  localparam int unsigned DW        = 32;
  localparam int unsigned AW        = 8;
  localparam int unsigned STRIDE_LG = 4;
  localparam int unsigned DEV_W     = $clog2(N_DEV);

  localparam logic [AW-1:0]        BASE_ADDR = 8'h30;
  localparam logic [STRIDE_LG-1:0] OFF_EVT   = 4'h0;
  localparam logic [STRIDE_LG-1:0] OFF_RST   = 4'h4;
  localparam logic [STRIDE_LG-1:0] OFF_MSK   = 4'h8;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_EVT,
    SEL_RST,
    SEL_MSK
  } reg_sel_e;
endpackage

// File: rtl/line_evt_sync.sv
`timescale 1ns/1ps
module line_evt_sync #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

  for (genvar b = 0; b < W; b++) begin : g_chk
    p_sync_delay_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(q_o[b]) |-> $past(d_i[b], 2));
  end
endmodule

// File: rtl/line_evt_dec.sv
`timescale 1ns/1ps
module line_evt_dec
  import line_evt_pkg::*;
(
  input  logic [AW-1:0]    addr_i,
  output logic             hit_o,
  output logic [DEV_W-1:0] dev_o,
  output reg_sel_e         sel_o
);
  logic [AW-1:0]           off;
  logic [AW-STRIDE_LG-1:0] slot;
  logic [STRIDE_LG-1:0]    low;

  assign off  = addr_i - BASE_ADDR;
  assign slot = off[AW-1:STRIDE_LG];
  assign low  = off[STRIDE_LG-1:0];

  always_comb begin
    hit_o = (addr_i >= BASE_ADDR) && (slot < (AW-STRIDE_LG)'(N_DEV));
    dev_o = off[STRIDE_LG +: DEV_W];
    sel_o = SEL_NONE;
    if (hit_o) begin
      unique case (low)
        OFF_EVT: sel_o = SEL_EVT;
        OFF_RST: sel_o = SEL_RST;
        OFF_MSK: sel_o = SEL_MSK;
        default: sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/line_evt_chan.sv
`timescale 1ns/1ps
module line_evt_chan #(
  parameter int unsigned N_EVT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] sync_evt_i,
  input  logic             wr_rst_i,
  input  logic             wr_msk_i,
  input  logic [N_EVT-1:0] wdata_i,
  output logic [N_EVT-1:0] evt_o,
  output logic [N_EVT-1:0] rst_o,
  output logic [N_EVT-1:0] msk_o,
  output logic             irq_o
);
  logic [N_EVT-1:0] evt_q, rst_q, msk_q, rst_nxt;

  // a reset write takes effect on the same edge, so a clear is never late
  assign rst_nxt = wr_rst_i ? wdata_i : rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= '0;
      rst_q <= '0;
      msk_q <= '0;
    end else begin
      rst_q <= rst_nxt;
      if (wr_msk_i) msk_q <= wdata_i;
      evt_q <= ~rst_nxt & (evt_q | sync_evt_i);
    end
  end

  assign evt_o = evt_q;
  assign rst_o = rst_q;
  assign msk_o = msk_q;
  assign irq_o = |(evt_q & msk_q);

  for (genvar k = 0; k < N_EVT; k++) begin : g_chk
    p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_q[k] && !rst_nxt[k]) |=> evt_q[k]);
    p_held_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_q[k] |-> !evt_q[k]);
    p_rearm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rst_nxt[k] && sync_evt_i[k]) |=> evt_q[k]);
  end
endmodule

// File: rtl/line_evt_bank.sv
`timescale 1ns/1ps
module line_evt_bank
  import line_evt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             wr_i,
  input  logic             rd_i,
  output logic [DW-1:0]    rdata_o,
  output logic             ack_o,
  output logic             irq_o,
  input  logic [N_DEV-1:0] los_i,
  input  logic [N_DEV-1:0] lol_i,
  input  logic [N_DEV-1:0] dmf_i
);
  localparam int unsigned NB = N_DEV * N_EVT;

  logic [NB-1:0]    raw_evt, sync_evt;
  logic             hit;
  logic [DEV_W-1:0] dev;
  reg_sel_e         sel;
  logic [N_EVT-1:0] evt_v [N_DEV];
  logic [N_EVT-1:0] rst_v [N_DEV];
  logic [N_EVT-1:0] msk_v [N_DEV];
  logic [N_DEV-1:0] irq_v, msk_any_v;
  logic [N_EVT-1:0] rd_val, rdata_q;
  logic             ack_q;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[DW-1:N_EVT];

  for (genvar d = 0; d < N_DEV; d++) begin : g_raw
    assign raw_evt[d*N_EVT +: N_EVT] = {dmf_i[d], lol_i[d], los_i[d]};
  end

  line_evt_sync #(.W(NB)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_evt),
    .q_o   (sync_evt)
  );

  line_evt_dec u_dec (
    .addr_i(addr_i),
    .hit_o (hit),
    .dev_o (dev),
    .sel_o (sel)
  );

  for (genvar d = 0; d < N_DEV; d++) begin : g_dev
    logic this_dev;
    assign this_dev = hit && (dev == DEV_W'(d));

    line_evt_chan #(.N_EVT(N_EVT)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sync_evt_i(sync_evt[d*N_EVT +: N_EVT]),
      .wr_rst_i  (wr_i && this_dev && (sel == SEL_RST)),
      .wr_msk_i  (wr_i && this_dev && (sel == SEL_MSK)),
      .wdata_i   (wdata_i[N_EVT-1:0]),
      .evt_o     (evt_v[d]),
      .rst_o     (rst_v[d]),
      .msk_o     (msk_v[d]),
      .irq_o     (irq_v[d])
    );
    assign msk_any_v[d] = |msk_v[d];
  end

  always_comb begin
    rd_val = '0;
    for (int d = 0; d < N_DEV; d++) begin
      if (dev == DEV_W'(d)) begin
        unique case (sel)
          SEL_EVT: rd_val = evt_v[d];
          SEL_RST: rd_val = rst_v[d];
          SEL_MSK: rd_val = msk_v[d];
          default: rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= wr_i | rd_i;
      rdata_q <= rd_i ? rd_val : '0;
    end
  end

  assign ack_o   = ack_q;
  assign rdata_o = {{(DW-N_EVT){1'b0}}, rdata_q};
  assign irq_o   = |irq_v;

  p_ack_after_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i || rd_i) |=> ack_o);
  p_no_stray_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i || rd_i) |=> !ack_o);
  p_irq_needs_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|msk_any_v));
endmodule

// File: tb/line_evt_bank_tb.sv
`timescale 1ns/1ps
module line_evt_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] rdata;
  logic        ack, irq;
  logic [3:0]  los = '0, lol = '0, dmf = '0;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  line_evt_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .ack_o(ack), .irq_o(irq),
    .los_i(los), .lol_i(lol), .dmf_i(dmf)
  );

  function automatic logic [7:0] ra(int d, int k);
    return 8'(8'h30 + 16*d + k);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    chk("R7 write ack", 32'(ack), 32'd1);
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    d = rdata;
    if (ack !== 1'b1) chk("R7 read ack", 32'(ack), 32'd1);
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    chk("R8 irq after reset", 32'(irq), 32'd0);
    chk("R7 no ack idle", 32'(ack), 32'd0);
    for (int d = 0; d < 4; d++)
      for (int k = 0; k < 12; k += 4) begin
        bus_rd(ra(d, k), v);
        chk("R8 reset value", v, 32'd0);
      end
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    for (int d = 0; d < 4; d++) begin
      bus_wr(ra(d, 8), 32'(d + 1));
      bus_wr(ra(d, 4), 32'(7 - d));
    end
    for (int d = 0; d < 4; d++) begin
      bus_rd(ra(d, 8), v); chk("R1 R8 mask readback", v, 32'(d + 1));
      bus_rd(ra(d, 4), v); chk("R1 R8 reset readback", v, 32'(7 - d));
      bus_rd(ra(d, 12), v); chk("R1 unused offset", v, 32'd0);
    end
    bus_wr(ra(2, 8), 32'hFFFF_FFFF);
    bus_rd(ra(2, 8), v); chk("R8 upper bits zero", v, 32'h7);
    for (int d = 0; d < 4; d++) begin
      bus_wr(ra(d, 8), 32'd0);
      bus_wr(ra(d, 4), 32'd0);
    end
  endtask

  task automatic t_sync_latency();
    bus_wr(ra(2, 8), 32'h1);
    @(negedge clk); los[2] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); chk("R2 not yet visible", 32'(irq), 32'd0);
    @(posedge clk);
    @(negedge clk); chk("R2 visible on third edge", 32'(irq), 32'd1);
    los[2] = 1'b0;
    bus_wr(ra(2, 4), 32'h1); bus_wr(ra(2, 4), 32'h0);
    bus_wr(ra(2, 8), 32'h0);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    @(negedge clk); los[1] = 1'b1;
    repeat (2) @(negedge clk); los[1] = 1'b0;
    settle();
    bus_rd(ra(1, 0), v); chk("R3 loss of signal bit0 sticky", v, 32'h1);
    @(negedge clk); lol[3] = 1'b1; dmf[0] = 1'b1;
    repeat (2) @(negedge clk); lol[3] = 1'b0; dmf[0] = 1'b0;
    settle();
    bus_rd(ra(3, 0), v); chk("R3 loss of lock bit1", v, 32'h2);
    bus_rd(ra(0, 0), v); chk("R3 driver monitor bit2", v, 32'h4);
    bus_rd(ra(2, 0), v); chk("R10 untouched device", v, 32'h0);
    bus_wr(ra(1, 0), 32'h0);
    bus_rd(ra(1, 0), v); chk("R9 event write ignored", v, 32'h1);
    bus_wr(ra(1, 4), 32'h1);
    bus_rd(ra(1, 0), v); chk("R4 clear device1", v, 32'h0);
    bus_rd(ra(3, 0), v); chk("R10 device3 kept", v, 32'h2);
    bus_wr(ra(1, 4), 32'h0);
    bus_rd(ra(1, 0), v); chk("R5 released with input low", v, 32'h0);
    bus_wr(ra(3, 4), 32'h7); bus_wr(ra(3, 4), 32'h0);
    bus_wr(ra(0, 4), 32'h7); bus_wr(ra(0, 4), 32'h0);
  endtask

  task automatic t_hold_rearm();
    logic [31:0] v;
    @(negedge clk); lol[0] = 1'b1;
    settle();
    bus_wr(ra(0, 4), 32'h2);
    bus_rd(ra(0, 0), v); chk("R4 cleared while input high", v, 32'h0);
    settle();
    bus_rd(ra(0, 0), v); chk("R4 still held", v, 32'h0);
    bus_wr(ra(0, 4), 32'h0);
    bus_rd(ra(0, 0), v); chk("R5 sets again after release", v, 32'h2);
    @(negedge clk); lol[0] = 1'b0;
    settle();
    bus_wr(ra(0, 4), 32'h2); bus_wr(ra(0, 4), 32'h0);
    bus_rd(ra(0, 0), v); chk("R5 stays clear after input gone", v, 32'h0);
  endtask

  task automatic t_irq_mask();
    @(negedge clk); dmf[3] = 1'b1;
    settle();
    @(negedge clk); chk("R6 irq masked off", 32'(irq), 32'd0);
    bus_wr(ra(3, 8), 32'h3);
    @(negedge clk); chk("R6 other bits masked", 32'(irq), 32'd0);
    bus_wr(ra(3, 8), 32'h4);
    @(negedge clk); chk("R6 irq enabled", 32'(irq), 32'd1);
    bus_wr(ra(1, 8), 32'h0);
    @(negedge clk); chk("R10 other device mask", 32'(irq), 32'd1);
    dmf[3] = 1'b0;
    settle();
    bus_wr(ra(3, 4), 32'h4);
    @(negedge clk); chk("R6 irq drops on clear", 32'(irq), 32'd0);
    bus_wr(ra(3, 4), 32'h0);
    bus_wr(ra(3, 8), 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_sync_latency();
    t_sticky();
    t_hold_rearm();
    t_irq_mask();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule